// File: doc/BRIEF.md
# Brown-out Reset Sequencer with Sticky Detector Keep-Alive

This block sits between an off-chip supply comparator and the reset network of a small microcontroller. It turns the comparator's "supply low" flag into a synchronous internal reset. It holds that reset while the supply is low. Once the supply is good again, it waits a fixed number of oscillator clocks before it releases reset. An external active-low reset pin drives the same release sequence.

The block also decides whether the comparator is powered. In normal run mode the detector is enabled. Power-down is entered with a two-step sequence: an arm strobe, then an enter strobe. In power-down the detector is normally switched off, so a low supply is not seen. A one-time keep-alive command keeps the detector on through power-down. That command is a sticky bit, and it is cleared only by a system reset. A wake strobe or an internal reset ends power-down.

Top module: `brownout_rst_seq`

## Requirements
- R1: While `rst_pin_n` is low, `sys_rst_o` is high at once, without waiting for a clock edge, and `det_en_o` is high.
- R2: After `rst_pin_n` rises with the supply good, `sys_rst_o` stays high and falls on the RELEASE_CYCLES-th rising edge (default 1376).
- R3: `supply_low_i` passes through two synchronizer flops. If it is raised while the detector is enabled, `sys_rst_o` rises on the third rising edge.
- R4: After `supply_low_i` returns low, `sys_rst_o` falls on rising edge RELEASE_CYCLES+2 (two synchronizer edges plus the release count).
- R5: If the synchronized supply flag goes low again during the release count, the count restarts from zero and reset stays high. A full count is then needed from the next recovery.
- R6: A one-cycle `pd_arm_i` pulse followed later by a `pd_enter_i` pulse enters power-down on the `pd_enter_i` edge. With keep-alive clear, `det_en_o` is then low. A `pd_enter_i` pulse with no arm pending has no effect.
- R7: While the detector is disabled in power-down, `supply_low_i` has no effect on `sys_rst_o`.
- R8: A `pd_wake_i` pulse ends power-down, and `det_en_o` is high after that edge.
- R9: After a `keep_on_i` pulse, `det_en_o` stays high in power-down, and a low supply in power-down raises `sys_rst_o`.
- R10: The keep-alive bit is cleared only by a system reset, either internal or from the pin. A `keep_on_i` pulse while `sys_rst_o` is high has no effect. Repeated pulses before a reset change nothing.
- R11: An internal reset ends power-down. After release, `det_en_o` is high with no wake pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| supply_low_i | input | 1 | Comparator flag, high when the supply is below threshold (asynchronous) |
| pd_arm_i | input | 1 | Power-down arm strobe |
| pd_enter_i | input | 1 | Power-down enter strobe |
| pd_wake_i | input | 1 | Wakeup event strobe |
| keep_on_i | input | 1 | Keep-detector-on command strobe |
| det_en_o | output | 1 | Detector enable |
| sys_rst_o | output | 1 | Internal reset, active high |

## Verification
The supply flag is tested four ways:
- A single drop and recovery shows the synchronizer latency on both edges.
- A second drop partway through the release count shows that the counter restarts rather than resumes.
- A drop in power-down with the keep bit clear shows that the disabled detector masks the flag.
- The same drop with the keep bit set shows that keep-alive restores detection.

Further runs check the stickiness of the keep bit. A keep pulse during reset, a brown-out reset and a pin reset are each followed by a fresh power-down, which shows whether the bit survived. An enter strobe without arming shows that the two-step entry is enforced.

// File: rtl/brownout_rst_seq.sv
module brownout_rst_seq #(
  parameter int RELEASE_CYCLES = 1376
) (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic supply_low_i,
  input  logic pd_arm_i,
  input  logic pd_enter_i,
  input  logic pd_wake_i,
  input  logic keep_on_i,
  output logic det_en_o,
  output logic sys_rst_o
);
  localparam int CNT_W = $clog2(RELEASE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_CYCLES - 1);

  logic             low_s1, low_s2;
  logic             in_rst, keep, armed, pd;
  logic [CNT_W-1:0] cnt;
  logic             low_det;

  assign det_en_o  = keep | ~pd;
  assign low_det   = det_en_o & low_s2;
  assign sys_rst_o = in_rst;

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      low_s1 <= 1'b0;
      low_s2 <= 1'b0;
    end else begin
      low_s1 <= supply_low_i;
      low_s2 <= low_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      in_rst <= 1'b1;
      cnt    <= '0;
    end else if (low_det) begin
      in_rst <= 1'b1;
      cnt    <= '0;
    end else if (in_rst) begin
      if (cnt == CNT_LAST) begin
        in_rst <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n)     keep <= 1'b0;
    else if (in_rst)    keep <= 1'b0;
    else if (keep_on_i) keep <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      armed <= 1'b0;
      pd    <= 1'b0;
    end else if (in_rst || pd_wake_i) begin
      armed <= 1'b0;
      pd    <= 1'b0;
    end else if (pd_enter_i && armed) begin
      armed <= 1'b0;
      pd    <= 1'b1;
    end else if (pd_arm_i) begin
      armed <= 1'b1;
    end
  end

  // R3
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(sys_rst_o) |-> $past(low_det));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    cnt <= CNT_LAST);

  // R4
  release_cnt_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(sys_rst_o) |-> ($past(cnt) == CNT_LAST && !$past(low_det)));

  // R6
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(pd) |-> $past(armed && pd_enter_i));

  // R10
  keep_clear_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(keep) |-> $past(in_rst));

  // R11
  rst_ends_pd_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    sys_rst_o |=> !pd);
endmodule

// File: tb/brownout_rst_seq_bench.sv
module brownout_rst_seq_bench;
  localparam int N = 1376;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic supply_low_i = 1'b0;
  logic pd_arm_i = 1'b0, pd_enter_i = 1'b0, pd_wake_i = 1'b0, keep_on_i = 1'b0;
  logic det_en_o, sys_rst_o;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  brownout_rst_seq #(.RELEASE_CYCLES(N)) u_brownout_rst_seq (
    .clk(clk), .rst_pin_n(rst_pin_n), .supply_low_i(supply_low_i),
    .pd_arm_i(pd_arm_i), .pd_enter_i(pd_enter_i), .pd_wake_i(pd_wake_i),
    .keep_on_i(keep_on_i), .det_en_o(det_en_o), .sys_rst_o(sys_rst_o));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic enter_pd();
    pulse(pd_arm_i); pulse(pd_enter_i);
  endtask

  task automatic wait_release(input int edges, input string req);
    step(edges - 1);
    check(req, sys_rst_o, 1'b1);
    step(1);
    check(req, sys_rst_o, 1'b0);
  endtask

  task automatic t_pin_reset();
    step(3);
    check("R1 rst", sys_rst_o, 1'b1);
    check("R1 det_en", det_en_o, 1'b1);
    rst_pin_n = 1'b1;
    wait_release(N, "R2");
  endtask

  task automatic t_brownout();
    supply_low_i = 1'b1;
    step(2);
    check("R3 before", sys_rst_o, 1'b0);
    step(1);
    check("R3 assert", sys_rst_o, 1'b1);
    step(5);
    supply_low_i = 1'b0;
    wait_release(N + 2, "R4");
  endtask

  task automatic t_redrop();
    supply_low_i = 1'b1; step(4); supply_low_i = 1'b0;
    step(100);
    supply_low_i = 1'b1; step(4);
    check("R5 held", sys_rst_o, 1'b1);
    supply_low_i = 1'b0;
    wait_release(N + 2, "R5");
  endtask

  task automatic t_powerdown();
    pulse(pd_enter_i);
    check("R6 no arm", det_en_o, 1'b1);
    enter_pd();
    check("R6 pd", det_en_o, 1'b0);
    supply_low_i = 1'b1; step(6);
    check("R7 masked", sys_rst_o, 1'b0);
    supply_low_i = 1'b0; step(3);
    check("R7 masked after", sys_rst_o, 1'b0);
    pulse(pd_wake_i);
    check("R8 wake", det_en_o, 1'b1);
  endtask

  task automatic t_keep();
    pulse(keep_on_i); step(2); pulse(keep_on_i);
    enter_pd();
    check("R9 det_en", det_en_o, 1'b1);
    supply_low_i = 1'b1; step(3);
    check("R9 reset", sys_rst_o, 1'b1);
    supply_low_i = 1'b0;
    wait_release(N + 2, "R9");
    check("R11 pd ended", det_en_o, 1'b1);
    enter_pd();
    check("R10 cleared by brownout", det_en_o, 1'b0);
    pulse(pd_wake_i);
  endtask

  task automatic t_keep_in_reset();
    supply_low_i = 1'b1; step(4);
    pulse(keep_on_i);
    supply_low_i = 1'b0;
    step(N + 2);
    check("R10 released", sys_rst_o, 1'b0);
    enter_pd();
    check("R10 ignored in reset", det_en_o, 1'b0);
    pulse(pd_wake_i);
  endtask

  task automatic t_keep_pin();
    pulse(keep_on_i);
    #3 rst_pin_n = 1'b0; #2;
    check("R1 async", sys_rst_o, 1'b1);
    step(2);
    rst_pin_n = 1'b1;
    wait_release(N, "R2 again");
    enter_pd();
    check("R10 cleared by pin", det_en_o, 1'b0);
    pulse(pd_wake_i);
    check("R8 wake again", det_en_o, 1'b1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_pin_reset();
        t_brownout();
        t_redrop();
        t_powerdown();
        t_keep();
        t_keep_in_reset();
        t_keep_pin();
        done = 1'b1;
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule